// File: doc/BRIEF.md
# Thermal Event Output Controller

This block turns a stream of signed temperature samples into an active-low, open-drain event flag. Each sample arrives with a valid strobe. It is compared against an upper limit, a lower limit and a critical limit, and one hysteresis value applies to all three. The block never drives the pin high. It only raises an enable that tells the pad to pull the line low, and the external pull-up returns the line high when the enable drops.

A mode select chooses how the flag behaves:

- **Interrupt mode:** a window violation latches the flag until software writes a clear strobe.
- **Comparator mode:** the flag tracks the window with hysteresis and releases by itself.
- **Critical-only mode:** only the critical limit can assert the flag.

In every mode the critical limit behaves like a comparator with hysteresis. It asserts above the limit and releases below the limit minus the hysteresis. A clear strobe therefore cannot release a critical event.

The block holds the most recent sample so the host can read it. It also keeps three status bits that report the raw comparison results of that sample.

Top module: `tevt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state is cleared. After reset, `evt_drive_low` is 0, `status` is 3'b000 and `temp_rd` is 0.
- R2: `temp_rd` takes `samp_temp` at each clock edge where `samp_valid` is 1. It holds its value otherwise.
- R3: On each valid sample, `status` is loaded with three bits. Bit 0 is sample > `lim_hi`, bit 1 is sample < `lim_lo` and bit 2 is sample > `lim_crit`. All comparisons are two's-complement. With no valid sample, `status` is unchanged.
- R4: The critical state works the same in every mode. A valid sample above `lim_crit` sets it. A valid sample below `lim_crit - hyst` clears it. Any other sample leaves it unchanged. While the critical state is set, `evt_drive_low` is 1.
- R5: Comparator mode (`mode` = 1) uses a window state. A valid sample above `lim_hi` or below `lim_lo` sets it. A valid sample that is below `lim_hi - hyst` and above `lim_lo + hyst` clears it. `evt_drive_low` equals window state OR critical state.
- R6: Interrupt mode (`mode` = 0) uses a latch. A valid sample above `lim_hi` or below `lim_lo` sets it. The latch holds until a cycle with `clr_wr` = 1 and no such sample. `evt_drive_low` equals latch OR critical state.
- R7: A clear strobe while the critical state is set leaves `evt_drive_low` at 1.
- R8: Critical-only mode (`mode` = 2) drives `evt_drive_low` from the critical state alone. Window violations have no effect on it.
- R9: `mode` = 3 behaves as comparator mode. At any clock edge where `mode` is not 0, the interrupt latch is cleared, so a latch does not survive leaving interrupt mode.
- R10: Each limit-minus-hysteresis and limit-plus-hysteresis threshold is computed two bits wider than the temperature width. A threshold beyond the 13-bit range does not wrap. `hyst` is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Sample strobe |
| samp_temp | input | 13 | Signed sample, 0.0625 °C per LSB |
| lim_hi | input | 13 | Signed upper window limit |
| lim_lo | input | 13 | Signed lower window limit |
| lim_crit | input | 13 | Signed critical limit |
| hyst | input | 13 | Unsigned hysteresis |
| mode | input | 2 | 0 interrupt, 1 comparator, 2 critical-only, 3 comparator |
| clr_wr | input | 1 | Write-1 clear of the interrupt latch |
| evt_drive_low | output | 1 | 1 = pull the event pin low |
| status | output | 3 | {above critical, below lower, above upper} |
| temp_rd | output | 13 | Most recent sample |

## Verification
The assertions assume the limits and hysteresis are steady while a sample is being judged. They also assume that `mode` only changes between samples. The bench meets both conditions: it changes limits and mode only in cycles without a valid sample, and it never raises a clear strobe in the same cycle as a sample. Inside those limits, the bench sweeps ramps of samples up and down through every threshold in each of the four mode codes. It then drives samples at the edges of the temperature range, where the hysteresis thresholds lie outside 13 bits.

// File: rtl/tevt_pkg.sv
// Package: shared mode encoding and status bit positions for the thermal
// event controller. Assumes a 2-bit mode select.
package tevt_pkg;
    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_CRIT = 2'd2,
        MODE_CMPB = 2'd3
    } evt_mode_e;

    localparam int STAT_W    = 3;
    localparam int STAT_HI   = 0;
    localparam int STAT_LO   = 1;
    localparam int STAT_CRIT = 2;
endpackage

// File: rtl/tevt_limit_cmp.sv
// Limit comparator: purely combinational signed compares of one sample
// against the window and critical limits, including hysteresis release
// thresholds. Assumes hyst is unsigned; the math is carried two bits
// wider than the sample so thresholds never wrap.
module tevt_limit_cmp #(
    parameter int TW = 13
) (
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] lim_hi,
    input  logic signed [TW-1:0] lim_lo,
    input  logic signed [TW-1:0] lim_crit,
    input  logic        [TW-1:0] hyst,
    output logic                 above_hi,
    output logic                 below_lo,
    output logic                 above_crit,
    output logic                 crit_release,
    output logic                 win_release
);
    localparam int XW = TW + 2;

    logic signed [XW-1:0] t_x, hi_x, lo_x, crit_x, h_x;

    // Sign-extend the signed operands and zero-extend the hysteresis.
    always_comb begin
        t_x    = {{2{temp[TW-1]}},     temp};
        hi_x   = {{2{lim_hi[TW-1]}},   lim_hi};
        lo_x   = {{2{lim_lo[TW-1]}},   lim_lo};
        crit_x = {{2{lim_crit[TW-1]}}, lim_crit};
        h_x    = {2'b00, hyst};
    end

    // Trip and release decisions for the window and critical limits.
    always_comb begin
        above_hi     = t_x > hi_x;
        below_lo     = t_x < lo_x;
        above_crit   = t_x > crit_x;
        crit_release = t_x < (crit_x - h_x);
        win_release  = (t_x < (hi_x - h_x)) && (t_x > (lo_x + h_x));
    end
endmodule

// File: rtl/tevt_state.sv
// Event state: registers the last sample, the status bits, the critical
// and window hysteresis states and the interrupt latch. Assumes compare
// results belong to the sample presented in the same cycle and that
// limits are steady while samp_valid is high.
module tevt_state
    import tevt_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_valid,
    input  logic signed [TW-1:0] samp_temp,
    input  logic [1:0]           mode,
    input  logic                 clr_wr,
    input  logic                 above_hi,
    input  logic                 below_lo,
    input  logic                 above_crit,
    input  logic                 crit_release,
    input  logic                 win_release,
    output logic signed [TW-1:0] temp_q,
    output logic [STAT_W-1:0]    stat_q,
    output logic                 crit_act,
    output logic                 win_act,
    output logic                 int_lat
);
    logic out_of_win;
    assign out_of_win = above_hi || below_lo;

    // Capture the sample value and raw comparison flags on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
            stat_q <= '0;
        end else if (samp_valid) begin
            temp_q            <= samp_temp;
            stat_q[STAT_HI]   <= above_hi;
            stat_q[STAT_LO]   <= below_lo;
            stat_q[STAT_CRIT] <= above_crit;
        end
    end

    // Critical hysteresis state, active in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                        crit_act <= 1'b0;
        else if (samp_valid && above_crit)   crit_act <= 1'b1;
        else if (samp_valid && crit_release) crit_act <= 1'b0;
    end

    // Window hysteresis state used by comparator mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                         win_act <= 1'b0;
        else if (samp_valid && out_of_win)  win_act <= 1'b1;
        else if (samp_valid && win_release) win_act <= 1'b0;
    end

    // Interrupt latch: set by a window violation, cleared by the strobe;
    // a new violation in the clear cycle wins; dropped outside interrupt mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          int_lat <= 1'b0;
        else if (mode != MODE_INT)           int_lat <= 1'b0;
        else if (samp_valid && out_of_win)   int_lat <= 1'b1;
        else if (clr_wr)                     int_lat <= 1'b0;
    end

    // R4
    crit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && above_crit) |=> crit_act);
    // R4
    crit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_act && !(samp_valid && crit_release)) |=> crit_act);
    // R6
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_lat && !clr_wr && mode == MODE_INT) |=> int_lat);
    // R3
    stat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> $stable(stat_q));
    // R2
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> $stable(temp_q));
endmodule

// File: rtl/tevt_top.sv
// Thermal event output controller top: wires the comparator to the state
// registers and selects the pin pull-low enable by mode. Assumes an
// external pull-up; the output only ever requests a low drive.
module tevt_top
    import tevt_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_valid,
    input  logic signed [TW-1:0] samp_temp,
    input  logic signed [TW-1:0] lim_hi,
    input  logic signed [TW-1:0] lim_lo,
    input  logic signed [TW-1:0] lim_crit,
    input  logic [TW-1:0]        hyst,
    input  logic [1:0]           mode,
    input  logic                 clr_wr,
    output logic                 evt_drive_low,
    output logic [2:0]           status,
    output logic signed [TW-1:0] temp_rd
);
    logic above_hi, below_lo, above_crit, crit_release, win_release;
    logic crit_act, win_act, int_lat;
    logic [STAT_W-1:0] stat_q;

    tevt_limit_cmp #(.TW(TW)) u_cmp (
        .temp         (samp_temp),
        .lim_hi       (lim_hi),
        .lim_lo       (lim_lo),
        .lim_crit     (lim_crit),
        .hyst         (hyst),
        .above_hi     (above_hi),
        .below_lo     (below_lo),
        .above_crit   (above_crit),
        .crit_release (crit_release),
        .win_release  (win_release)
    );

    tevt_state #(.TW(TW)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_valid   (samp_valid),
        .samp_temp    (samp_temp),
        .mode         (mode),
        .clr_wr       (clr_wr),
        .above_hi     (above_hi),
        .below_lo     (below_lo),
        .above_crit   (above_crit),
        .crit_release (crit_release),
        .win_release  (win_release),
        .temp_q       (temp_rd),
        .stat_q       (stat_q),
        .crit_act     (crit_act),
        .win_act      (win_act),
        .int_lat      (int_lat)
    );

    assign status = stat_q;

    // Mode select of the pull-low enable; critical always participates.
    always_comb begin
        case (evt_mode_e'(mode))
            MODE_INT:  evt_drive_low = int_lat || crit_act;
            MODE_CRIT: evt_drive_low = crit_act;
            default:   evt_drive_low = win_act || crit_act;
        endcase
    end

    // R4
    crit_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_act |-> evt_drive_low);
    // R8
    critonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CRIT && !crit_act) |-> !evt_drive_low);
    // R7
    clr_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_act && clr_wr && !samp_valid) |=> evt_drive_low);
endmodule

// File: tb/tevt_top_tb.sv
module tevt_top_tb;
    localparam int TW = 13;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, samp_valid, clr_wr;
    logic [1:0] mode;
    logic signed [TW-1:0] samp_temp, lim_hi, lim_lo, lim_crit;
    logic [TW-1:0] hyst;
    logic evt_drive_low;
    logic [2:0] status;
    logic signed [TW-1:0] temp_rd;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int m_temp;
    bit m_crit, m_win, m_lat;
    bit [2:0] m_stat;

    tevt_top #(.TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst(hyst),
        .mode(mode), .clr_wr(clr_wr), .evt_drive_low(evt_drive_low),
        .status(status), .temp_rd(temp_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_evt();
        case (mode)
            2'd0:    return m_lat | m_crit;
            2'd2:    return m_crit;
            default: return m_win | m_crit;
        endcase
    endfunction

    function automatic string evt_tag();
        if (m_crit)      return "R4";
        case (mode)
            2'd0:    return "R6";
            2'd1:    return "R5";
            2'd2:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_all();
        chk(evt_tag(), int'(evt_drive_low), int'(exp_evt()));
        chk("R3", int'(status), int'(m_stat));
        chk("R2", int'(temp_rd), m_temp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; samp_valid = 1'b0; clr_wr = 1'b0; samp_temp = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_temp = 0; m_crit = 0; m_win = 0; m_lat = 0; m_stat = 3'b000;
        chk("R1", int'(evt_drive_low), 0);
        chk("R1", int'(status), 0);
        chk("R1", int'(temp_rd), 0);
    endtask

    task automatic do_sample(input int t);
        int hi, lo, cr, h;
        samp_temp = t[TW-1:0];
        samp_valid = 1'b1;
        @(negedge clk);
        samp_valid = 1'b0;
        hi = int'(lim_hi); lo = int'(lim_lo); cr = int'(lim_crit); h = int'(hyst);
        m_temp = t;
        m_stat = {t > cr, t < lo, t > hi};
        if (t > cr) m_crit = 1;
        else if (t < cr - h) m_crit = 0;
        if (t > hi || t < lo) m_win = 1;
        else if (t < hi - h && t > lo + h) m_win = 0;
        if (mode != 2'd0) m_lat = 0;
        else if (t > hi || t < lo) m_lat = 1;
        check_all();
    endtask

    task automatic do_clear();
        clr_wr = 1'b1;
        @(negedge clk);
        clr_wr = 1'b0;
        m_lat = 0;
        chk(m_crit ? "R7" : "R6", int'(evt_drive_low), int'(exp_evt()));
    endtask

    task automatic do_idle();
        @(negedge clk);
        if (mode != 2'd0) m_lat = 0;
        chk("R9", int'(evt_drive_low), int'(exp_evt()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; samp_valid = 1'b0; clr_wr = 1'b0; mode = 2'd0;
        samp_temp = '0;
        lim_hi = 13'sd20; lim_lo = -13'sd10; lim_crit = 13'sd30; hyst = 13'd4;

        // ramps through every threshold in each mode code
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            do_reset();
            for (int t = -40; t <= 40; t++) begin
                do_sample(t);
                if (m == 0 && (t % 7) == 0) do_clear();
            end
            for (int t = 40; t >= -40; t--) begin
                do_sample(t);
                if (m == 0 && (t % 7) == 0) do_clear();
            end
        end

        // R9: latch dropped when leaving interrupt mode
        mode = 2'd0;
        do_reset();
        do_sample(25);
        mode = 2'd2;
        do_idle();
        mode = 2'd0;
        do_idle();

        // R10: thresholds beyond the 13-bit range do not wrap
        mode = 2'd1;
        do_reset();
        lim_hi = 13'sd4095; lim_lo = -13'sd4096;
        lim_crit = -13'sd4090; hyst = 13'd20;
        do_sample(-4000);
        do_sample(-4096);
        chk("R10", int'(evt_drive_low), 1);
        lim_crit = 13'sd0; hyst = 13'd8191;
        do_sample(1);
        do_sample(-4096);
        chk("R10", int'(evt_drive_low), 1);
        lim_crit = 13'sd4094; hyst = 13'd0;
        do_sample(4095);
        do_sample(4093);
        chk("R10", int'(evt_drive_low), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule